// File: doc/BRIEF.md
# BERT Receive Pattern Checker

This block checks a received serial test stream against a known pattern and measures its error rate. A host picks the pattern family and then raises a resynchronize command. The checker fills a local reference from the incoming bits. It then predicts each following bit and compares the prediction with the bit received. After a run of clean comparisons it declares lock. While locked it counts received bits and mismatched bits. If errors bunch up, it drops lock and acquires the stream again without help from the host.

A second host command takes a snapshot of the counts. It copies the live bit and error counts into the latched output registers and starts a new measurement period from zero, both in the same cycle. Both commands act only on a rising edge. Three enable inputs gate the event pulses for a lock change, a counted bit error and a counter reaching all ones.

Top module: `bert_rx_sync`

## Requirements
- R1: After reset the checker is idle and never locks until a 0-to-1 transition of `resyncCmd`. That transition restarts acquisition and drops lock. Holding `resyncCmd` high does not restart it again.
- R2: `patSel` and `repLenCode` are sampled only on the resync transition. `patSel` codes: 0 = PRBS with b[n]=b[n-7]^b[n-6], 1 = b[n]=b[n-11]^b[n-9], 2 = b[n]=b[n-15]^b[n-14], 4 = repetitive. Codes 3, 5, 6 and 7 never lock.
- R3: After a (re)seed, the first N valid bits (N = 7, 11 or 15) load the reference. `syncOk` goes high right after the clock edge that takes the 32nd following error-free bit. An error among those 32 bits forces a reseed.
- R4: In repetitive mode the period is L = 17 + `repLenCode`. L bits are captured, the 32-bit verify follows, and comparison then runs cyclically. `repLenCode` has no effect in the PRBS modes.
- R5: When `rxInvert` is 1, every received bit is complemented before it is used.
- R6: Counted bits are grouped into aligned blocks of 64, the first block starting at lock. A block may hold up to 5 errors with lock kept. The 6th error in a block drops `syncOk` on that bit, and a reseed starts at once.
- R7: Bits and errors are counted only while locked. Each counted error gives a one-cycle `bitErrEvt`. The latched error count never exceeds the latched bit count.
- R8: A 0-to-1 transition of `loadCmd` copies the live counts to `bitCountLatched`/`errCountLatched` and clears the live counts. The latched values change at no other time, and holding `loadCmd` high has no further effect.
- R9: A bit counted in the same cycle as a snapshot goes into the new period, not into the latched value.
- R10: The counters stop at all ones (CNT_W bits). The step that reaches all ones pulses `overflowEvt` once.
- R11: `syncChangeEvt` pulses in the cycle after every change of `syncOk`. Each event pulse is suppressed while its enable input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | A received bit is present this cycle |
| bitIn | input | 1 | Received bit |
| rxInvert | input | 1 | Complement received bits |
| patSel | input | 3 | Pattern family code |
| repLenCode | input | 4 | Repetitive period code, L = 17 + code |
| resyncCmd | input | 1 | Resynchronize command, rising-edge active |
| loadCmd | input | 1 | Snapshot command, rising-edge active |
| syncIrqEn | input | 1 | Enable for syncChangeEvt |
| errIrqEn | input | 1 | Enable for bitErrEvt |
| ovfIrqEn | input | 1 | Enable for overflowEvt |
| syncOk | output | 1 | Checker is locked |
| syncChangeEvt | output | 1 | Lock state changed |
| bitErrEvt | output | 1 | A counted bit was in error |
| overflowEvt | output | 1 | A counter reached all ones |
| bitCountLatched | output | CNT_W | Bit count of the last closed period |
| errCountLatched | output | CNT_W | Error count of the last closed period |

## Verification
The hardest case to reach is loss of lock at the edge of the 64-bit block. Only the block boundaries decide whether a burst is 5 or 6 errors in one block, and those boundaries are counted from the lock point, which is not visible at the ports. The bench counts the bits it delivers after each observed lock, so it can tell where a block starts. It then places a 5-error burst and a 6-error burst inside one block each, so the cycle in which lock is lost is known exactly. Counter saturation is reached with a narrow counter width. A snapshot is issued in the same cycle as a counted bit.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_LOCK} syncState_t;

  typedef struct packed {
    logic reseed;     // clear the reference fill, begin seeding
    logic latchMode;  // sample pattern select and length with reseed
    logic countBit;   // this valid bit belongs to the locked period
    logic snap;       // copy live counts to latched and clear
  } dpStrobe_t;

  localparam logic [2:0] MODE_P7  = 3'd0;
  localparam logic [2:0] MODE_P11 = 3'd1;
  localparam logic [2:0] MODE_P15 = 3'd2;
  localparam logic [2:0] MODE_REP = 3'd4;
endpackage

// File: rtl/bert_rx_datapath.sv
module bert_rx_datapath
  import bert_rx_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HIST_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             rxInvert,
  input  logic [2:0]       patSel,
  input  logic [3:0]       repLenCode,
  input  dpStrobe_t        strb,
  output logic             seedDone,
  output logic             errNow,
  output logic             ovfNow,
  output logic [CNT_W-1:0] bitCountLatched,
  output logic [CNT_W-1:0] errCountLatched
);
  localparam int IDX_W = $clog2(HIST_W);
  localparam int FILL_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] REP_TAP_BASE = IDX_W'(HIST_W - 16);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]        modeQ;
  logic [IDX_W-1:0]  repTapQ;
  logic [HIST_W-1:0] hist;
  logic [FILL_W-1:0] fillCnt;
  logic [FILL_W-1:0] seedLen;
  logic              legal;
  logic              predBit;
  logic              rxBit;
  logic [CNT_W-1:0]  bitLive;
  logic [CNT_W-1:0]  errLive;
  logic              bitInc;
  logic              errInc;

  // prediction: PRBS feedback taps or the oldest stored repetitive bit
  always_comb begin
    legal   = 1'b1;
    predBit = 1'b0;
    seedLen = '0;
    case (modeQ)
      MODE_P7:  begin seedLen = FILL_W'(7);  predBit = hist[6] ^ hist[5];   end
      MODE_P11: begin seedLen = FILL_W'(11); predBit = hist[10] ^ hist[8];  end
      MODE_P15: begin seedLen = FILL_W'(15); predBit = hist[14] ^ hist[13]; end
      MODE_REP: begin seedLen = FILL_W'(repTapQ) + FILL_W'(1); predBit = hist[repTapQ]; end
      default:  legal = 1'b0;
    endcase
  end

  assign rxBit    = bitIn ^ rxInvert;
  assign seedDone = legal && (fillCnt == seedLen);
  assign errNow   = bitValid && seedDone && (rxBit != predBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_P7;
      repTapQ <= REP_TAP_BASE;
      hist    <= '0;
      fillCnt <= '0;
    end else if (strb.reseed) begin
      fillCnt <= '0;
      if (strb.latchMode) begin
        modeQ   <= patSel;
        repTapQ <= REP_TAP_BASE + IDX_W'(repLenCode);
      end
    end else if (bitValid && legal) begin
      if (!seedDone) begin
        hist    <= {hist[HIST_W-2:0], rxBit};
        fillCnt <= fillCnt + FILL_W'(1);
      end else begin
        hist <= {hist[HIST_W-2:0], predBit};  // self-running: errors do not pollute
      end
    end
  end

  // measurement counters with saturation and snapshot
  assign bitInc = strb.countBit && (bitLive != CNT_MAX);
  assign errInc = strb.countBit && errNow && (errLive != CNT_MAX);
  assign ovfNow = !strb.snap &&
                  ((bitInc && bitLive == CNT_MAX - CNT_W'(1)) ||
                   (errInc && errLive == CNT_MAX - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitLive         <= '0;
      errLive         <= '0;
      bitCountLatched <= '0;
      errCountLatched <= '0;
    end else if (strb.snap) begin
      bitCountLatched <= bitLive;
      errCountLatched <= errLive;
      bitLive         <= CNT_W'(strb.countBit);
      errLive         <= CNT_W'(strb.countBit && errNow);
    end else begin
      bitLive <= bitLive + CNT_W'(bitInc);
      errLive <= errLive + CNT_W'(errInc);
    end
  end
endmodule

// File: rtl/bert_rx_control.sv
module bert_rx_control
  import bert_rx_pkg::*;
#(
  parameter int GOOD_RUN      = 32,
  parameter int WIN_LEN       = 64,
  parameter int WIN_ERR_LIMIT = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      resyncCmd,
  input  logic      loadCmd,
  input  logic      seedDone,
  input  logic      errNow,
  input  logic      ovfNow,
  input  logic      syncIrqEn,
  input  logic      errIrqEn,
  input  logic      ovfIrqEn,
  output dpStrobe_t strb,
  output logic      syncOk,
  output logic      syncChangeEvt,
  output logic      bitErrEvt,
  output logic      overflowEvt
);
  localparam int GOOD_W = $clog2(GOOD_RUN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int WERR_W = $clog2(WIN_ERR_LIMIT + 1);

  syncState_t        state, stateNext;
  logic              resyncPrev, loadPrev;
  logic              resyncEdge, loadEdge;
  logic [GOOD_W-1:0] goodCnt, goodNext;
  logic [WIN_W-1:0]  winCnt, winCntNext;
  logic [WERR_W-1:0] winErr, winErrNext;

  assign resyncEdge = resyncCmd && !resyncPrev;
  assign loadEdge   = loadCmd && !loadPrev;

  always_comb begin
    stateNext     = state;
    goodNext      = goodCnt;
    winCntNext    = winCnt;
    winErrNext    = winErr;
    strb          = '0;
    strb.snap     = loadEdge;
    strb.countBit = (state == ST_LOCK) && bitValid;
    if (resyncEdge) begin
      stateNext      = ST_HUNT;
      goodNext       = '0;
      strb.reseed    = 1'b1;
      strb.latchMode = 1'b1;
    end else begin
      case (state)
        ST_HUNT: if (bitValid && seedDone) begin
          if (errNow) begin
            goodNext    = '0;
            strb.reseed = 1'b1;
          end else if (goodCnt == GOOD_W'(GOOD_RUN - 1)) begin
            stateNext  = ST_LOCK;
            goodNext   = '0;
            winCntNext = '0;
            winErrNext = '0;
          end else begin
            goodNext = goodCnt + GOOD_W'(1);
          end
        end
        ST_LOCK: if (bitValid) begin
          if (errNow && winErr == WERR_W'(WIN_ERR_LIMIT - 1)) begin
            stateNext   = ST_HUNT;
            strb.reseed = 1'b1;
          end else if (winCnt == WIN_W'(WIN_LEN - 1)) begin
            winCntNext = '0;
            winErrNext = '0;
          end else begin
            winCntNext = winCnt + WIN_W'(1);
            winErrNext = winErr + WERR_W'(errNow);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      resyncPrev    <= 1'b0;
      loadPrev      <= 1'b0;
      goodCnt       <= '0;
      winCnt        <= '0;
      winErr        <= '0;
      syncOk        <= 1'b0;
      syncChangeEvt <= 1'b0;
      bitErrEvt     <= 1'b0;
      overflowEvt   <= 1'b0;
    end else begin
      state         <= stateNext;
      resyncPrev    <= resyncCmd;
      loadPrev      <= loadCmd;
      goodCnt       <= goodNext;
      winCnt        <= winCntNext;
      winErr        <= winErrNext;
      syncOk        <= (stateNext == ST_LOCK);
      syncChangeEvt <= syncIrqEn && ((stateNext == ST_LOCK) != (state == ST_LOCK));
      bitErrEvt     <= errIrqEn && strb.countBit && errNow;
      overflowEvt   <= ovfIrqEn && ovfNow;
    end
  end
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
  import bert_rx_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             rxInvert,
  input  logic [2:0]       patSel,
  input  logic [3:0]       repLenCode,
  input  logic             resyncCmd,
  input  logic             loadCmd,
  input  logic             syncIrqEn,
  input  logic             errIrqEn,
  input  logic             ovfIrqEn,
  output logic             syncOk,
  output logic             syncChangeEvt,
  output logic             bitErrEvt,
  output logic             overflowEvt,
  output logic [CNT_W-1:0] bitCountLatched,
  output logic [CNT_W-1:0] errCountLatched
);
  dpStrobe_t strb;
  logic      seedDone;
  logic      errNow;
  logic      ovfNow;

  bert_rx_control i_control (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .resyncCmd(resyncCmd),
    .loadCmd(loadCmd), .seedDone(seedDone), .errNow(errNow), .ovfNow(ovfNow),
    .syncIrqEn(syncIrqEn), .errIrqEn(errIrqEn), .ovfIrqEn(ovfIrqEn),
    .strb(strb), .syncOk(syncOk), .syncChangeEvt(syncChangeEvt),
    .bitErrEvt(bitErrEvt), .overflowEvt(overflowEvt)
  );

  bert_rx_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .rxInvert(rxInvert), .patSel(patSel), .repLenCode(repLenCode),
    .strb(strb), .seedDone(seedDone), .errNow(errNow), .ovfNow(ovfNow),
    .bitCountLatched(bitCountLatched), .errCountLatched(errCountLatched)
  );
endmodule

// File: rtl/bert_rx_sync_sva.sv
module bert_rx_sync_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadCmd,
  input logic             syncIrqEn,
  input logic             ovfIrqEn,
  input logic             syncOk,
  input logic             syncChangeEvt,
  input logic             bitErrEvt,
  input logic             overflowEvt,
  input logic [CNT_W-1:0] bitCountLatched,
  input logic [CNT_W-1:0] errCountLatched
);
  AST_ERR_WITHIN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    errCountLatched <= bitCountLatched); // R7
  AST_ERR_EVT_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    bitErrEvt |-> $past(syncOk)); // R7
  AST_SNAP_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadCmd) |-> ($stable(bitCountLatched) && $stable(errCountLatched))); // R8
  AST_OVF_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    overflowEvt |-> $past(syncOk)); // R10
  AST_SYNC_EVT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncIrqEn) && (syncOk != $past(syncOk))) |-> syncChangeEvt); // R11
  AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ovfIrqEn) |-> !overflowEvt); // R11
endmodule

bind bert_rx_sync bert_rx_sync_sva #(.CNT_W(CNT_W)) i_bert_rx_sync_sva (
  .clk(clk), .rstN(rstN), .loadCmd(loadCmd), .syncIrqEn(syncIrqEn),
  .ovfIrqEn(ovfIrqEn), .syncOk(syncOk), .syncChangeEvt(syncChangeEvt),
  .bitErrEvt(bitErrEvt), .overflowEvt(overflowEvt),
  .bitCountLatched(bitCountLatched), .errCountLatched(errCountLatched)
);

// File: tb/test_bert_rx_sync.sv
module test_bert_rx_sync;
  localparam int CNT_W = 10;
  localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, bitIn = 1'b0, rxInvert = 1'b0;
  logic [2:0] patSel = 3'd0;
  logic [3:0] repLenCode = 4'd0;
  logic resyncCmd = 1'b0, loadCmd = 1'b0;
  logic syncIrqEn = 1'b1, errIrqEn = 1'b1, ovfIrqEn = 1'b1;
  logic syncOk, syncChangeEvt, bitErrEvt, overflowEvt;
  logic [CNT_W-1:0] bitCountLatched, errCountLatched;

  int checks = 0;
  int errors = 0;
  int benchMode = 0;
  logic [31:0] gs = 32'h5a;
  logic [31:0] repPat = '0;
  int repLen = 17;
  int repIdx = 0;
  int lockPos = 0;

  always #2.5 clk = ~clk;

  bert_rx_sync #(.CNT_W(CNT_W)) i_bert_rx_sync (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .rxInvert(rxInvert), .patSel(patSel), .repLenCode(repLenCode),
    .resyncCmd(resyncCmd), .loadCmd(loadCmd), .syncIrqEn(syncIrqEn),
    .errIrqEn(errIrqEn), .ovfIrqEn(ovfIrqEn), .syncOk(syncOk),
    .syncChangeEvt(syncChangeEvt), .bitErrEvt(bitErrEvt),
    .overflowEvt(overflowEvt), .bitCountLatched(bitCountLatched),
    .errCountLatched(errCountLatched)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // next bit of the transmitted test pattern
  function automatic logic genBit();
    logic nb;
    case (benchMode)
      0: nb = gs[6] ^ gs[5];
      1: nb = gs[10] ^ gs[8];
      2: nb = gs[14] ^ gs[13];
      default: begin
        nb = repPat[repIdx];
        repIdx = (repIdx + 1) % repLen;
      end
    endcase
    gs = {gs[30:0], nb};
    return nb;
  endfunction

  task automatic pushBit(input logic b);
    logic wasSync;
    wasSync = syncOk;
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    if (wasSync) lockPos++;
    if (!wasSync && syncOk) lockPos = 0;
  endtask

  task automatic sendNext(input logic flip);
    pushBit(genBit() ^ flip ^ rxInvert);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseResync();
    resyncCmd = 1'b1;
    @(negedge clk);
    resyncCmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseLoad();
    loadCmd = 1'b1;
    @(negedge clk);
    loadCmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic newPrbs(input int m);
    benchMode = m;
    gs = $urandom() | 32'h1;
  endtask

  // expect lock exactly after the n-th clean bit
  task automatic acquire(input string tag, input int n);
    for (int i = 1; i <= n; i++) begin
      sendNext(1'b0);
      if (i == n - 1) chk({tag, " not yet locked"}, syncOk, 0);
    end
    chk({tag, " locked"}, syncOk, 1);
    chk({tag, " R11 lock event"}, syncChangeEvt, syncIrqEn);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 reset syncOk", syncOk, 0);
    chk("R1 reset bit count", bitCountLatched, 0);
    chk("R1 reset err count", errCountLatched, 0);
    chk("R1 reset events", {syncChangeEvt, bitErrEvt, overflowEvt}, 0);

    // R1: no lock without a resync command
    begin
      int seen = 0;
      newPrbs(0);
      for (int i = 0; i < 80; i++) begin
        sendNext(1'b0);
        if (syncOk) seen = 1;
      end
      chk("R1 idle never locks", seen, 0);
    end

    // R3: PRBS7 acquisition, 7 seed + 32 verify
    patSel = 3'd0;
    pulseResync();
    acquire("R3 prbs7", 39);
    pulseLoad();
    chk("R7 nothing counted before lock", bitCountLatched, 0);

    // R7: counting with sparse random errors (4 per any 64 bits at most)
    begin
      int expErr = 0;
      for (int i = 0; i < 200; i++) begin
        logic f;
        f = (i % 16 == 5) && ($urandom() % 2 == 1);
        sendNext(f);
        if (f) begin
          expErr++;
          chk("R7 error event", bitErrEvt, 1);
        end
      end
      pulseLoad();
      chk("R7 bit count", bitCountLatched, 200);
      chk("R7 error count", errCountLatched, expErr);
      chk("R6 sparse errors keep lock", syncOk, 1);
    end

    // R9: snapshot in the same cycle as a counted bit
    loadCmd = 1'b1;
    sendNext(1'b0);
    loadCmd = 1'b0;
    chk("R9 same-cycle bit excluded", bitCountLatched, 0);
    for (int i = 0; i < 9; i++) sendNext(1'b0);
    pulseLoad();
    chk("R9 same-cycle bit in new period", bitCountLatched, 10);

    // R8: held load command snapshots once
    loadCmd = 1'b1;
    @(negedge clk);
    chk("R8 first snapshot", bitCountLatched, 0);
    for (int i = 0; i < 20; i++) sendNext(1'b0);
    chk("R8 held high no snapshot", bitCountLatched, 0);
    loadCmd = 1'b0;
    @(negedge clk);
    pulseLoad();
    chk("R8 next snapshot", bitCountLatched, 20);

    // R6: 5 errors in a block keep lock, the 6th drops it
    while (lockPos % 64 != 0) sendNext(1'b0);
    for (int i = 0; i < 64; i++) sendNext(i < 10 && (i % 2 == 1));
    chk("R6 five errors tolerated", syncOk, 1);
    for (int i = 0; i < 6; i++) begin
      sendNext(1'b1);
      if (i == 4) chk("R6 lock after 5th error", syncOk, 1);
    end
    chk("R6 lost on 6th error", syncOk, 0);
    chk("R11 loss event", syncChangeEvt, 1);
    acquire("R6 auto reseed", 39);

    // R2/R4: PRBS11, length code ignored; later select change has no effect
    newPrbs(1);
    patSel = 3'd1;
    repLenCode = 4'($urandom());
    pulseResync();
    acquire("R4 prbs11 code ignored", 43);
    patSel = 3'd0;
    repLenCode = 4'd15;
    pulseLoad();
    for (int i = 0; i < 100; i++) sendNext(1'b0);
    pulseLoad();
    chk("R2 select sampled at resync errs", errCountLatched, 0);
    chk("R2 select sampled at resync bits", bitCountLatched, 100);

    // R1: held resync restarts once only
    newPrbs(0);
    resyncCmd = 1'b1;
    @(negedge clk);
    chk("R1 resync drops lock", syncOk, 0);
    acquire("R1 resync held high", 39);
    resyncCmd = 1'b0;
    @(negedge clk);

    // R5: inverted reception, PRBS15
    rxInvert = 1'b1;
    newPrbs(2);
    patSel = 3'd2;
    pulseResync();
    acquire("R5 inverted prbs15", 47);
    pulseLoad();
    for (int i = 0; i < 100; i++) sendNext(1'b0);
    pulseLoad();
    chk("R5 inverted no errors", errCountLatched, 0);
    rxInvert = 1'b0;

    // R4: repetitive, L = 20 then L = 17
    benchMode = 4; repLen = 20; repIdx = 0; repPat = $urandom();
    patSel = 3'd4; repLenCode = 4'd3;
    pulseResync();
    acquire("R4 repetitive L20", 52);
    pulseLoad();
    for (int i = 0; i < 100; i++) sendNext(i == 30 || i == 77);
    pulseLoad();
    chk("R4 repetitive errors", errCountLatched, 2);
    chk("R4 repetitive bits", bitCountLatched, 100);
    repLen = 17; repIdx = 0; repPat = $urandom();
    repLenCode = 4'd0;
    pulseResync();
    acquire("R4 repetitive L17", 49);

    // R2: unsupported code never locks
    begin
      int seen = 0;
      patSel = 3'd6;
      pulseResync();
      for (int i = 0; i < 150; i++) begin
        sendNext(1'b0);
        if (syncOk) seen = 1;
      end
      chk("R2 illegal code never locks", seen, 0);
    end

    // R11: disabled events
    syncIrqEn = 1'b0;
    errIrqEn = 1'b0;
    newPrbs(0);
    patSel = 3'd0;
    pulseResync();
    acquire("R11 sync event disabled", 39);
    pulseLoad();
    sendNext(1'b1);
    chk("R11 error event disabled", bitErrEvt, 0);
    pulseLoad();
    chk("R11 error still counted", errCountLatched, 1);
    syncIrqEn = 1'b1;
    errIrqEn = 1'b1;

    // R10: saturation and overflow event
    begin
      int early = 0;
      for (int i = 0; i < CNT_MAX - 1; i++) begin
        sendNext(1'b0);
        if (overflowEvt) early = 1;
      end
      chk("R10 no early overflow", early, 0);
      sendNext(1'b0);
      chk("R10 overflow at all ones", overflowEvt, 1);
      sendNext(1'b0);
      chk("R10 overflow single pulse", overflowEvt, 0);
      for (int i = 0; i < 5; i++) sendNext(1'b0);
      pulseLoad();
      chk("R10 saturated bit count", bitCountLatched, CNT_MAX);
      chk("R10 error count", errCountLatched, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule